// File: doc/BRIEF.md
# Transmit Command Prefix Inserter

This block sits in an Ethernet transmit path, ahead of a transport that needs to know each frame's size before the frame's bytes arrive. The payload length comes in on a sideband valid/ready channel. The payload bytes follow on a byte stream with valid/ready flow control. For each frame, the block first sends eight bytes of command prefix and then the payload itself, unchanged.

The prefix is made of two 32-bit words, each sent least significant byte first. The leading word holds the length together with two flags that mark the frame as both the opening and the closing segment. The trailing word holds the length on its own. A one-entry length slot lets the next frame's length arrive while the current payload is still streaming. When the slot is filled in time, the next prefix follows the previous frame's final byte with no idle cycle between them.

A length of zero, or one above 2047, is refused. The refusal shows as an error pulse, and no output is produced for that length.

Top module: `tx_cmd_prefix`

## Requirements
- R1: Each accepted length L produces exactly L+8 output bytes: 8 prefix bytes followed by L payload bytes.
- R2: Prefix bytes 0 to 3 are the leading word, least significant byte first. The length sits in bits 10:0, the closing-segment flag in bit 12 and the opening-segment flag in bit 13, and all other bits are zero. So byte 0 is len[7:0], byte 1 is 0x30 OR len[10:8], and bytes 2 and 3 are 0x00.
- R3: Prefix bytes 4 to 7 are the trailing word, least significant byte first, holding the length in bits 10:0. So byte 4 is len[7:0], byte 5 is len[10:8] and bytes 6 and 7 are 0x00.
- R4: Payload bytes leave in arrival order with their values unchanged. During the payload, an input byte is taken only in a cycle in which the output byte is taken.
- R5: outLast is high on the final payload byte of each frame and on no other transferred byte.
- R6: An offered length of 0 or above 2047 is consumed without producing a frame. lenErr is then high for exactly the one cycle after that handshake. lenErr is never high otherwise.
- R7: While the output is stalled (outReady low) during the prefix, outValid stays high and outData keeps its value. No byte is lost or repeated.
- R8: Suppose the next frame's length was accepted before the cycle in which the current frame's final byte is transferred. Then the first prefix byte of the next frame is valid in the very next cycle.
- R9: After a valid length is accepted, lenReady is low in the next cycle. A length offered while lenReady is low is not taken.
- R10: After reset, outValid is low, lenReady is high and lenErr is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lenValid | input | 1 | Frame length offered |
| lenReady | output | 1 | Length slot is free |
| lenValue | input | LEN_W | Payload length in bytes |
| lenErr | output | 1 | One-cycle pulse after a refused length |
| inValid | input | 1 | Payload byte offered |
| inReady | output | 1 | Payload byte taken this cycle |
| inData | input | 8 | Payload byte |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream takes the byte |
| outData | output | 8 | Prefix or payload byte |
| outLast | output | 1 | Marks the final payload byte |

## Verification
Two things can happen in the same cycle. One is the transfer of a frame's final payload byte, together with moving the waiting length into the active frame. The other is accepting a new length on the sideband while payload is still streaming. The bench provokes both by offering short frames one after another, so that each next length is already held when the current frame ends. It then checks in the following cycle that a prefix byte is valid and that its value belongs to the new frame. It also checks that lenReady fell right after each acceptance, so that a third length is not swallowed.

// File: rtl/txcmd_pkg.sv
package txcmd_pkg;
  localparam int HDR_BYTES  = 8;
  localparam int FIELD_W    = 11;
  localparam int FIRST_FLAG = 13;
  localparam int LAST_FLAG  = 12;
  localparam int IDX_W      = $clog2(HDR_BYTES);

  typedef enum logic [1:0] {PH_IDLE, PH_HDR, PH_PAY} phase_e;

  typedef struct packed {
    logic takeLen;
    logic startFrame;
    logic hdrStep;
    logic payStep;
  } strobe_t;

  function automatic logic [7:0] hdrByte(input logic [IDX_W-1:0] idx,
                                         input logic [FIELD_W-1:0] len);
    logic [31:0] wordA;
    logic [31:0] wordB;
    logic [63:0] both;
    wordA = 32'(len);
    wordA[FIRST_FLAG] = 1'b1;
    wordA[LAST_FLAG]  = 1'b1;
    wordB = 32'(len);
    both  = {wordB, wordA};
    return both[8*idx +: 8];
  endfunction
endpackage

// File: rtl/txcmd_ctrl.sv
module txcmd_ctrl
  import txcmd_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int MAX_LEN = 2047
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lenValid,
  input  logic [LEN_W-1:0] lenValue,
  input  logic             pendFull,
  input  logic             hdrDone,
  input  logic             payFinal,
  input  logic             inValid,
  input  logic             outReady,
  output logic             lenReady,
  output logic             lenErr,
  output logic             outValid,
  output logic             inReady,
  output logic             outLast,
  output phase_e           phase,
  output strobe_t          strobes
);
  phase_e phaseNext;
  logic   lenOk, offerTaken, hdrXfer, payXfer, frameEnd;

  assign lenReady   = !pendFull;
  assign offerTaken = lenValid && lenReady;
  assign lenOk      = (lenValue != '0) && (lenValue <= LEN_W'(MAX_LEN));
  assign hdrXfer    = (phase == PH_HDR) && outReady;
  assign payXfer    = (phase == PH_PAY) && inValid && outReady;
  assign frameEnd   = payXfer && payFinal;

  always_comb begin
    strobes.takeLen    = offerTaken && lenOk;
    strobes.startFrame = pendFull && ((phase == PH_IDLE) || frameEnd);
    strobes.hdrStep    = hdrXfer;
    strobes.payStep    = payXfer;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (strobes.startFrame) phaseNext = PH_HDR;
      PH_HDR:  if (hdrXfer && hdrDone) phaseNext = PH_PAY;
      PH_PAY:  if (frameEnd) phaseNext = strobes.startFrame ? PH_HDR : PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      lenErr <= 1'b0;
    end else begin
      phase  <= phaseNext;
      lenErr <= offerTaken && !lenOk;
    end
  end

  assign outValid = (phase == PH_HDR) || ((phase == PH_PAY) && inValid);
  assign inReady  = (phase == PH_PAY) && outReady;
  assign outLast  = (phase == PH_PAY) && payFinal;
endmodule

// File: rtl/txcmd_datapath.sv
module txcmd_datapath
  import txcmd_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  phase_e           phase,
  input  logic [LEN_W-1:0] lenValue,
  input  logic [7:0]       inData,
  output logic             pendFull,
  output logic             hdrDone,
  output logic             payFinal,
  output logic [7:0]       outData
);
  logic [FIELD_W-1:0] pendLen, curLen, remain;
  logic [IDX_W-1:0]   idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendFull <= 1'b0;
      pendLen  <= '0;
      curLen   <= '0;
      remain   <= '0;
      idx      <= '0;
    end else begin
      if (strobes.takeLen) begin
        pendLen  <= lenValue[FIELD_W-1:0];
        pendFull <= 1'b1;
      end else if (strobes.startFrame) begin
        pendFull <= 1'b0;
      end
      if (strobes.startFrame) begin
        curLen <= pendLen;
        remain <= pendLen;
        idx    <= '0;
      end else begin
        if (strobes.hdrStep) idx <= idx + 1'b1;
        if (strobes.payStep) remain <= remain - 1'b1;
      end
    end
  end

  assign hdrDone  = (idx == IDX_W'(HDR_BYTES - 1));
  assign payFinal = (remain == FIELD_W'(1));
  assign outData  = (phase == PH_HDR) ? hdrByte(idx, curLen) : inData;
endmodule

// File: rtl/tx_cmd_prefix.sv
module tx_cmd_prefix
  import txcmd_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int MAX_LEN = 2047
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lenValid,
  output logic             lenReady,
  input  logic [LEN_W-1:0] lenValue,
  output logic             lenErr,
  input  logic             inValid,
  output logic             inReady,
  input  logic [7:0]       inData,
  output logic             outValid,
  input  logic             outReady,
  output logic [7:0]       outData,
  output logic             outLast
);
  strobe_t strobes;
  phase_e  phase;
  logic    pendFull, hdrDone, payFinal;

  txcmd_ctrl #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .lenValid(lenValid), .lenValue(lenValue),
    .pendFull(pendFull), .hdrDone(hdrDone), .payFinal(payFinal),
    .inValid(inValid), .outReady(outReady), .lenReady(lenReady),
    .lenErr(lenErr), .outValid(outValid), .inReady(inReady),
    .outLast(outLast), .phase(phase), .strobes(strobes)
  );

  txcmd_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .phase(phase),
    .lenValue(lenValue), .inData(inData), .pendFull(pendFull),
    .hdrDone(hdrDone), .payFinal(payFinal), .outData(outData)
  );
endmodule

// File: rtl/txcmd_checker.sv
module txcmd_checker #(
  parameter int LEN_W   = 12,
  parameter int MAX_LEN = 2047
) (
  input logic             clk,
  input logic             rstN,
  input logic             lenValid,
  input logic             lenReady,
  input logic [LEN_W-1:0] lenValue,
  input logic             lenErr,
  input logic             inValid,
  input logic             inReady,
  input logic [7:0]       inData,
  input logic             outValid,
  input logic             outReady,
  input logic [7:0]       outData,
  input logic             outLast
);
  localparam int BEAT_W = LEN_W + 1;
  logic [BEAT_W-1:0] beat;
  logic [7:0]        lenLo;
  logic [2:0]        lenHi;
  logic              xfer, badOffer, goodOffer;

  assign xfer      = outValid && outReady;
  assign badOffer  = lenValid && lenReady && ((lenValue == '0) || (lenValue > LEN_W'(MAX_LEN)));
  assign goodOffer = lenValid && lenReady && !((lenValue == '0) || (lenValue > LEN_W'(MAX_LEN)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beat  <= '0;
      lenLo <= '0;
      lenHi <= '0;
    end else if (xfer) begin
      beat <= outLast ? '0 : beat + 1'b1;
      if (beat == BEAT_W'(0)) lenLo <= outData;
      if (beat == BEAT_W'(1)) lenHi <= outData[2:0];
    end
  end

  p_frame_size_r1: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && outLast) |-> (beat == BEAT_W'({lenHi, lenLo}) + BEAT_W'(7)));
  p_flags_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && beat == BEAT_W'(1)) |-> (outData[7:3] == 5'b00110));
  p_len_repeat_r3: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && beat == BEAT_W'(4)) |-> (outData == lenLo));
  p_forward_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> (xfer && outData == inData));
  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |-> $past(badOffer));
  p_hdr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && beat < BEAT_W'(8)) |=> (outValid && $stable(outData)));
  p_slot_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    goodOffer |=> !lenReady);
endmodule

bind tx_cmd_prefix txcmd_checker #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .lenValid(lenValid), .lenReady(lenReady),
  .lenValue(lenValue), .lenErr(lenErr), .inValid(inValid), .inReady(inReady),
  .inData(inData), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outLast(outLast)
);

// File: tb/tx_cmd_prefix_bench.sv
module tx_cmd_prefix_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 12;
  localparam int MAX_LEN    = 2047;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic [7:0] d;
    bit         last;
    bit         hdr;
    int         req;
  } item_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             lenValid = 1'b0;
  logic             lenReady;
  logic [LEN_W-1:0] lenValue = '0;
  logic             lenErr;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [7:0]       inData = '0;
  logic             outValid;
  logic             outReady = 1'b1;
  logic [7:0]       outData;
  logic             outLast;

  int    checks = 0, failures = 0;
  item_t expQ[$];
  int    payLenQ[$];
  int    paySerQ[$];
  int    lenPlan[$];
  int    serial = 0, accepted = 0, framesDone = 0;
  int    errExp = 0, errSeen = 0, b2bChecks = 0;
  bit    bpMode = 0, gapMode = 0, finished = 0;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_cmd_prefix #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_tx_cmd_prefix (
    .clk(clk), .rstN(rstN), .lenValid(lenValid), .lenReady(lenReady),
    .lenValue(lenValue), .lenErr(lenErr), .inValid(inValid), .inReady(inReady),
    .inData(inData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outLast(outLast)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] payByte(input int ser, input int i);
    return 8'((ser * 53 + i * 7 + 3) & 255);
  endfunction

  // Back-pressure pattern, driven just after each rising edge
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady = bpMode ? (lfsr[0] | lfsr[1]) : 1'b1;
  end

  // Monitor: samples at the falling edge
  initial begin
    bit    stallHdr = 0;
    bit    wantHdr = 0;
    logic [7:0] stallData = '0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (lenErr) errSeen++;
        if (wantHdr) begin
          check(outValid, "R8 next prefix without gap", outValid, 1);
          b2bChecks++;
          wantHdr = 0;
        end
        if (stallHdr)
          check(outValid && outData == stallData, "R7 stalled prefix byte held", outData, stallData);
        stallHdr = outValid && !outReady && expQ.size() > 0 && expQ[0].hdr;
        stallData = outData;
        if (outValid && outReady) begin
          if (expQ.size() == 0) begin
            check(0, "R1 unexpected output byte", outData, 0);
          end else begin
            item_t it;
            it = expQ.pop_front();
            check(outData == it.d, $sformatf("R%0d byte value", it.req), outData, it.d);
            check(outLast == it.last, "R5 last marker", outLast, it.last);
            if (it.last) begin
              framesDone++;
              if (accepted > framesDone) wantHdr = 1;
            end
          end
        end
      end
    end
  end

  task automatic lenDriver();
    foreach (lenPlan[k]) begin
      int  L;
      bit  ok, got;
      L  = lenPlan[k];
      ok = (L != 0) && (L <= MAX_LEN);
      lenValid = 1'b1;
      lenValue = LEN_W'(L);
      do begin
        @(negedge clk); got = lenReady;
        @(posedge clk); #1;
      end while (!got);
      lenValid = 1'b0;
      if (ok) begin
        item_t h;
        serial++;
        for (int b = 0; b < 8; b++) begin
          logic [63:0] words;
          // R2 leading word: len | bit12 | bit13 ; R3 trailing word: len
          words = {32'(L), 32'(L) | 32'h3000};
          h.d = words[8*b +: 8]; h.last = 0; h.hdr = 1; h.req = (b < 4) ? 2 : 3;
          expQ.push_back(h);
        end
        for (int i = 0; i < L; i++) begin
          h.d = payByte(serial, i); h.last = (i == L - 1); h.hdr = 0; h.req = 4;
          expQ.push_back(h);
        end
        payLenQ.push_back(L);
        paySerQ.push_back(serial);
        accepted++;
        @(negedge clk);
        check(!lenReady, "R9 slot closed after accept", lenReady, 0);
        check(!lenErr, "R6 no error for good length", lenErr, 0);
      end else begin
        errExp++;
        @(negedge clk);
        check(lenErr, "R6 error pulse for bad length", lenErr, 1);
      end
      @(posedge clk); #1;
    end
  endtask

  task automatic payDriver(input int goodN);
    for (int f = 0; f < goodN; f++) begin
      int L, s;
      while (payLenQ.size() == 0) begin @(posedge clk); #1; end
      L = payLenQ.pop_front();
      s = paySerQ.pop_front();
      for (int i = 0; i < L; i++) begin
        bit got;
        if (gapMode && (i % 3 == 1)) begin
          inValid = 1'b0; @(posedge clk); #1;
        end
        inValid = 1'b1;
        inData  = payByte(s, i);
        do begin
          @(negedge clk); got = inReady;
          @(posedge clk); #1;
        end while (!got);
      end
      inValid = 1'b0;
    end
  endtask

  task automatic runBatch();
    int goodN = 0;
    foreach (lenPlan[k]) if (lenPlan[k] != 0 && lenPlan[k] <= MAX_LEN) goodN++;
    fork
      lenDriver();
      payDriver(goodN);
    join
    while (expQ.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!outValid, "R10 outValid low after reset", outValid, 0);
    check(lenReady, "R10 lenReady high after reset", lenReady, 1);
    check(!lenErr, "R10 lenErr low after reset", lenErr, 0);
    @(posedge clk); #1;

    // R1 R2 R3 R4 R5: plain frames, no stalls
    lenPlan = '{1, 5, 64};
    runBatch();
    // R6 R7: refused lengths, max length, back-pressure
    bpMode = 1;
    lenPlan = '{0, 7, 2048, 4095, 2047};
    runBatch();
    // R8 R9: short frames queued behind each other
    bpMode = 0;
    lenPlan = '{3, 1, 1, 2, 40, 17};
    runBatch();
    // R4 R7: input gaps with back-pressure
    bpMode = 1; gapMode = 1;
    lenPlan = '{9, 33, 6};
    runBatch();

    check(errSeen == errExp, "R6 error pulse count", errSeen, errExp);
    check(b2bChecks > 0, "R8 back-to-back case reached", b2bChecks, 1);
    check(framesDone == accepted, "R1 frame count", framesDone, accepted);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule